// File: doc/BRIEF.md
# Multi-Channel DMA Request Controller

This block keeps the programming state for a set of DMA channels and rules on every transfer request a device raises against them. Each channel has four 32-bit slots in a small register window: a spare word, a control word with an enable bit, a direction bit and three status flags, a remaining byte count, and a start address. Software programs these slots over a simple register port before a transfer.

A device asks its channel for a transfer by raising a request line. It gives its own direction, device write (data into memory) or device read (data out of memory), and the length it wants. When several channels ask in the same cycle, one is served and the rest wait. The served channel's flags are cleared first. If the channel is not enabled, or the direction does not agree with its control word, the channel records a memory error and a sticky per-channel bit is set in an error summary word. Otherwise the block hands the start address and the granted length to an external data mover, sets the terminal-count flag and reduces the count. The block does not move data and does not translate addresses.

Top module: `dmacc_top`

## Requirements
- R1: After a synchronous active-high reset, every slot of every channel and the error summary read as zero, and neither xfer_vld nor xfer_err is high.
- R2: Channel c, slot s sits at byte address 0x100 + 32*c + 8*s (address bits 1:0 ignored). Slot 1 is the control word, slot 2 is the count and slot 3 is the address. A written value reads back unchanged when no request is served. A read outside the channel window and away from 0x200 returns zero.
- R3: Serving a request first clears control bits 10:8 (bit 8 terminal count, bit 9 memory error, bit 10 address error). After the request exactly one of bit 8 and bit 9 is set, and bit 10 is clear.
- R4: A request to a channel whose control bit 0 (enable) is clear sets control bit 9 and summary bit c. It pulses xfer_err for one cycle with no xfer_vld, and it leaves the count and the address unchanged.
- R5: Control bit 1 clear accepts only device writes (req_dwr=1). Bit 1 set accepts only device reads (req_dwr=0). A direction mismatch on an enabled channel behaves as in R4.
- R6: A consistent request issues xfer_addr equal to the address slot and xfer_len equal to the smaller of the requested length and the count. It sets control bit 8 and lowers the count by xfer_len, and it leaves the address slot unchanged.
- R7: The error summary at address 0x200 holds one bit per channel. A bit stays set until reset, and writes to 0x200 have no effect.
- R8: One request is served per cycle. req_ack is one-hot on the lowest-numbered requesting channel, and channels that are not served keep all their registers.
- R9: req_ack responds in the same cycle as the request. xfer_vld or xfer_err, with xfer_ch, follows on the next cycle, and both stay low the cycle after a cycle with no request.
- R10: When a register write hits the served channel's control or count slot in the same cycle, the written value is stored in that slot and the request's update to that slot is lost. The transfer result still uses the values held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| req_vld | input | NCH | Per-channel transfer request |
| req_dwr | input | NCH | Per-channel direction, 1 = device write into memory |
| req_len | input | NCH*DATA_W | Per-channel requested length in bytes |
| req_ack | output | NCH | One-hot mark of the channel served this cycle |
| xfer_vld | output | 1 | Grant issued to the data mover |
| xfer_err | output | 1 | Served request was refused as inconsistent |
| xfer_ch | output | CH_W | Channel of the grant or refusal |
| xfer_addr | output | DATA_W | Start address of the grant, zero on refusal |
| xfer_len | output | DATA_W | Granted length, zero on refusal |

## Verification
The embedded assertions watch things that must hold on every cycle. The flags must leave a single outcome after each request. The count must never rise, and the address must never move because of a request. Summary bits must never clear outside reset. At most one channel may be acknowledged, and a result must follow every acknowledge and only an acknowledge. Only the bench scenarios can show the values themselves: that the length is clipped to the right minimum, that the refusal logic matches the truth table over enable, direction bit and requested direction on every channel, that the lowest channel wins among all 255 request masks, and that a register write in the same cycle as a request wins its slot.

// File: rtl/dmacc_pkg.sv
package dmacc_pkg;

    localparam int DATA_W   = 32;
    localparam int SLOTS    = 4;

    localparam int SLOT_CTL = 1;
    localparam int SLOT_CNT = 2;
    localparam int SLOT_ADR = 3;

    localparam int BIT_EN   = 0;
    localparam int BIT_M2D  = 1;
    localparam int BIT_TC   = 8;
    localparam int BIT_MERR = 9;
    localparam int BIT_AERR = 10;

    localparam logic [DATA_W-1:0] FLAG_MASK =
        (DATA_W'(1) << BIT_TC) | (DATA_W'(1) << BIT_MERR) | (DATA_W'(1) << BIT_AERR);

    typedef struct packed {
        logic              err;
        logic [DATA_W-1:0] glen;
        logic [DATA_W-1:0] ctl_nx;
        logic [DATA_W-1:0] cnt_nx;
    } eval_t;

    // Outcome of serving one request against a channel's control and count.
    function automatic eval_t eval_req(input logic [DATA_W-1:0] ctl,
                                       input logic [DATA_W-1:0] cnt,
                                       input logic              dev_wr,
                                       input logic [DATA_W-1:0] len);
        eval_t             r;
        logic [DATA_W-1:0] base;
        base  = ctl & ~FLAG_MASK;
        r.err = !ctl[BIT_EN] || (dev_wr == ctl[BIT_M2D]);
        if (r.err) begin
            r.glen   = '0;
            r.ctl_nx = base | (DATA_W'(1) << BIT_MERR);
            r.cnt_nx = cnt;
        end else begin
            r.glen   = (len < cnt) ? len : cnt;
            r.ctl_nx = base | (DATA_W'(1) << BIT_TC);
            r.cnt_nx = cnt - r.glen;
        end
        return r;
    endfunction

endpackage

// File: rtl/dmacc_arb.sv
module dmacc_arb #(
    parameter int NCH  = 8,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]  req,
    output logic [NCH-1:0]  gnt,
    output logic [CH_W-1:0] gnt_idx,
    output logic            any
);
    // Isolate the lowest set bit: fixed priority, channel 0 highest.
    assign gnt = req & (~req + NCH'(1));
    assign any = |req;

    always_comb begin
        gnt_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) gnt_idx = CH_W'(i);
        end
    end
endmodule

// File: rtl/dmacc_chan.sv
module dmacc_chan
    import dmacc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_slot,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        svc,
    input  logic                        dev_wr,
    input  logic [DATA_W-1:0]           len,
    output logic [SLOTS-1:0][DATA_W-1:0] slots,
    output logic                        ev_err,
    output logic [DATA_W-1:0]           ev_glen
);
    eval_t ev;
    logic  wr_ctl, wr_cnt;

    assign ev      = eval_req(slots[SLOT_CTL], slots[SLOT_CNT], dev_wr, len);
    assign ev_err  = ev.err;
    assign ev_glen = ev.glen;
    assign wr_ctl  = wr_en && (wr_slot == 2'(SLOT_CTL));
    assign wr_cnt  = wr_en && (wr_slot == 2'(SLOT_CNT));

    always_ff @(posedge clk) begin
        if (rst) begin
            slots <= '0;
        end else begin
            if (wr_en && (wr_slot == 2'd0))    slots[0] <= wr_data;
            if (wr_ctl)                        slots[SLOT_CTL] <= wr_data;
            else if (svc)                      slots[SLOT_CTL] <= ev.ctl_nx;
            if (wr_cnt)                        slots[SLOT_CNT] <= wr_data;
            else if (svc)                      slots[SLOT_CNT] <= ev.cnt_nx;
            if (wr_en && (wr_slot == 2'(SLOT_ADR))) slots[SLOT_ADR] <= wr_data;
        end
    end

    // R3: a served request leaves exactly one outcome flag, address-error clear
    p_one_outcome_r3: assert property (@(posedge clk) disable iff (rst)
        (svc && !wr_ctl) |=> ($countones(slots[SLOT_CTL][BIT_MERR:BIT_TC]) == 1
                              && !slots[SLOT_CTL][BIT_AERR]));

    // R6: serving never raises the count
    p_count_no_rise_r6: assert property (@(posedge clk) disable iff (rst)
        (svc && !wr_cnt) |=> (slots[SLOT_CNT] <= $past(slots[SLOT_CNT])));

    // R6: the address slot is not advanced by a request
    p_addr_held_r6: assert property (@(posedge clk) disable iff (rst)
        (svc && !(wr_en && wr_slot == 2'(SLOT_ADR))) |=> $stable(slots[SLOT_ADR]));

    // R4: a refused request leaves the count as it was
    p_refuse_keeps_count_r4: assert property (@(posedge clk) disable iff (rst)
        (svc && ev_err && !wr_cnt) |=> $stable(slots[SLOT_CNT]));
endmodule

// File: rtl/dmacc_top.sv
module dmacc_top
    import dmacc_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int ADDR_W    = 10,
    parameter int BANK_BASE = 'h100,
    parameter int SUM_OFS   = 'h200,
    localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CH_BYTES = 32,
    localparam int BANK_END = BANK_BASE + NCH * CH_BYTES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    input  logic                  reg_we,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NCH-1:0]        req_vld,
    input  logic [NCH-1:0]        req_dwr,
    input  logic [NCH*DATA_W-1:0] req_len,
    output logic [NCH-1:0]        req_ack,
    output logic                  xfer_vld,
    output logic                  xfer_err,
    output logic [CH_W-1:0]       xfer_ch,
    output logic [DATA_W-1:0]     xfer_addr,
    output logic [DATA_W-1:0]     xfer_len
);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

    logic [ADDR_W-1:0]            a_w, offs;
    logic                         bank_hit, sum_hit;
    logic [CH_W-1:0]              sel_ch, win;
    logic [1:0]                   sel_slot;
    logic                         any_req;
    logic [NCH-1:0]               err_vec, err_sum;
    logic [SLOTS-1:0][DATA_W-1:0] ch_slots [NCH];
    logic [DATA_W-1:0]            glen_vec [NCH];

    // Register window decode
    assign a_w      = reg_addr & WORD_MASK;
    assign bank_hit = (a_w >= ADDR_W'(BANK_BASE)) && (a_w < ADDR_W'(BANK_END));
    assign sum_hit  = (a_w == ADDR_W'(SUM_OFS));
    assign offs     = a_w - ADDR_W'(BANK_BASE);
    assign sel_ch   = CH_W'(offs >> 5);
    assign sel_slot = 2'(offs >> 3);

    dmacc_arb #(.NCH(NCH)) u_arb (
        .req     (req_vld),
        .gnt     (req_ack),
        .gnt_idx (win),
        .any     (any_req)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dmacc_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (reg_we && bank_hit && (sel_ch == CH_W'(c))),
            .wr_slot (sel_slot),
            .wr_data (reg_wdata),
            .svc     (req_ack[c]),
            .dev_wr  (req_dwr[c]),
            .len     (req_len[c*DATA_W +: DATA_W]),
            .slots   (ch_slots[c]),
            .ev_err  (err_vec[c]),
            .ev_glen (glen_vec[c])
        );
    end

    always_comb begin
        if (bank_hit)     reg_rdata = ch_slots[sel_ch][sel_slot];
        else if (sum_hit) reg_rdata = DATA_W'(err_sum);
        else              reg_rdata = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_sum   <= '0;
            xfer_vld  <= 1'b0;
            xfer_err  <= 1'b0;
            xfer_ch   <= '0;
            xfer_addr <= '0;
            xfer_len  <= '0;
        end else begin
            err_sum   <= err_sum | (req_ack & err_vec);
            xfer_vld  <= any_req && !err_vec[win];
            xfer_err  <= any_req && err_vec[win];
            xfer_ch   <= win;
            xfer_addr <= (any_req && !err_vec[win]) ? ch_slots[win][SLOT_ADR] : '0;
            xfer_len  <= (any_req && !err_vec[win]) ? glen_vec[win] : '0;
        end
    end

    // R8: at most one channel served per cycle
    p_single_grant_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_ack));

    // R8: only a requesting channel may be acknowledged
    p_ack_requested_r8: assert property (@(posedge clk) disable iff (rst)
        ((req_ack & ~req_vld) == '0));

    // R9: every acknowledge yields exactly one of grant or refusal next cycle
    p_result_follows_r9: assert property (@(posedge clk) disable iff (rst)
        (|req_ack) |=> (xfer_vld ^ xfer_err));

    // R9: no request, no result
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !(|req_vld) |=> (!xfer_vld && !xfer_err));

    // R7: summary bits never clear outside reset
    p_sum_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(err_sum) & ~err_sum) == '0));
endmodule

// File: tb/dmacc_top_tb.sv
module dmacc_top_tb_top;
    localparam int CLK_P = 10;
    localparam int NCH   = 8;
    localparam int DW    = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [9:0]        reg_addr = '0;
    logic [DW-1:0]     reg_wdata = '0;
    logic              reg_we = 1'b0;
    logic [DW-1:0]     reg_rdata;
    logic [NCH-1:0]    req_vld = '0;
    logic [NCH-1:0]    req_dwr = '0;
    logic [NCH*DW-1:0] req_len = '0;
    logic [NCH-1:0]    req_ack;
    logic              xfer_vld, xfer_err;
    logic [2:0]        xfer_ch;
    logic [DW-1:0]     xfer_addr, xfer_len;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] m_ctl [NCH];
    logic [DW-1:0] m_cnt [NCH];
    logic [DW-1:0] m_adr [NCH];
    logic [NCH-1:0] m_sum;

    always #(CLK_P/2) clk = ~clk;

    dmacc_top dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .req_vld(req_vld),
        .req_dwr(req_dwr), .req_len(req_len), .req_ack(req_ack),
        .xfer_vld(xfer_vld), .xfer_err(xfer_err), .xfer_ch(xfer_ch),
        .xfer_addr(xfer_addr), .xfer_len(xfer_len)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] slot_addr(input int c, input int s);
        return 10'(32'h100 + 32 * c + 8 * s);
    endfunction

    task automatic wr(input logic [9:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            m_ctl[c] = '0; m_cnt[c] = '0; m_adr[c] = '0;
        end
        m_sum = '0;
    endtask

    // Model of one served request, from the requirements.
    task automatic model_serve(input int c, input logic dwr, input logic [DW-1:0] len,
                               output logic err, output logic [DW-1:0] gl);
        err = !m_ctl[c][0] || (dwr == m_ctl[c][1]);
        m_ctl[c] = m_ctl[c] & ~32'h700;
        if (err) begin
            gl = '0;
            m_ctl[c] = m_ctl[c] | 32'h200;
            m_sum[c] = 1'b1;
        end else begin
            gl = (len < m_cnt[c]) ? len : m_cnt[c];
            m_ctl[c] = m_ctl[c] | 32'h100;
            m_cnt[c] = m_cnt[c] - gl;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        logic          e;
        logic [DW-1:0] gl;

        do_reset();
        // R1: reset state
        #1;
        check("R1 xfer_vld", DW'(xfer_vld), 0);
        check("R1 xfer_err", DW'(xfer_err), 0);
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < 4; s++) begin
                rd(slot_addr(c, s), v);
                check("R1 slot", v, 0);
            end
        rd(10'h200, v); check("R1 summary", v, 0);

        // R2: map and read-back, with low address bits ignored
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < 4; s++)
                wr(slot_addr(c, s) | 10'(s & 3), 32'hA500_0000 + 32'(c * 16 + s));
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < 4; s++) begin
                rd(slot_addr(c, s), v);
                check("R2 readback", v, 32'hA500_0000 + 32'(c * 16 + s));
            end
        rd(10'h000, v); check("R2 unmapped 0x000", v, 0);
        rd(10'h208, v); check("R2 unmapped 0x208", v, 0);
        rd(10'h0fc, v); check("R2 unmapped 0x0fc", v, 0);
        // R7: write to summary has no effect
        wr(10'h200, 32'hFFFF_FFFF);
        rd(10'h200, v); check("R7 summary write ignored", v, 0);

        // R3 R4 R5 R6: sweep channel x enable x direction bit x requested direction
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 8; k++) begin
                logic en, m2d, dwr;
                logic [DW-1:0] len;
                en = k[0]; m2d = k[1]; dwr = k[2];
                len = 32'(50 + 40 * ((c + k) % 3));
                m_ctl[c] = 32'h700 | {30'd0, m2d, en};
                m_cnt[c] = 32'(100 + c);
                m_adr[c] = 32'h1000 * 32'(c) + 32'h40;
                wr(slot_addr(c, 1), m_ctl[c]);
                wr(slot_addr(c, 2), m_cnt[c]);
                wr(slot_addr(c, 3), m_adr[c]);
                @(negedge clk);
                req_vld = NCH'(1) << c;
                req_dwr = NCH'(dwr) << c;
                req_len = '0;
                req_len[c*DW +: DW] = len;
                #1 check("R9 ack same cycle", DW'(req_ack), DW'(NCH'(1) << c));
                model_serve(c, dwr, len, e, gl);
                @(negedge clk);
                req_vld = '0;
                check(e ? "R4 R5 xfer_err" : "R6 xfer_err", DW'(xfer_err), DW'(e));
                check(e ? "R4 R5 xfer_vld" : "R6 xfer_vld", DW'(xfer_vld), DW'(!e));
                check("R9 xfer_ch", DW'(xfer_ch), DW'(c));
                if (!e) begin
                    check("R6 xfer_addr", xfer_addr, m_adr[c]);
                    check("R6 xfer_len", xfer_len, gl);
                end
                rd(slot_addr(c, 1), v); check("R3 control flags", v, m_ctl[c]);
                rd(slot_addr(c, 2), v); check("R6 count", v, m_cnt[c]);
                rd(slot_addr(c, 3), v); check("R6 address held", v, m_adr[c]);
                rd(10'h200, v); check("R7 summary", v, DW'(m_sum));
                #1 check("R9 idle quiet", DW'(xfer_vld | xfer_err), 0);
            end

        // R8: priority over every request mask
        do_reset();
        for (int c = 0; c < NCH; c++) begin
            m_ctl[c] = 32'h1; m_cnt[c] = 32'd1000; m_adr[c] = 32'(c * 4);
            wr(slot_addr(c, 1), m_ctl[c]);
            wr(slot_addr(c, 2), m_cnt[c]);
            wr(slot_addr(c, 3), m_adr[c]);
        end
        for (int m = 1; m < 256; m++) begin
            int w;
            w = 0;
            for (int i = NCH - 1; i >= 0; i--) if (m[i]) w = i;
            @(negedge clk);
            req_vld = NCH'(m);
            req_dwr = '1;
            for (int i = 0; i < NCH; i++) req_len[i*DW +: DW] = 32'd1;
            #1 check("R8 lowest wins", DW'(req_ack), DW'(NCH'(1) << w));
            model_serve(w, 1'b1, 32'd1, e, gl);
            @(negedge clk);
            req_vld = '0;
            check("R8 xfer_ch", DW'(xfer_ch), DW'(w));
            check("R8 xfer_vld", DW'(xfer_vld), 1);
        end
        for (int c = 0; c < NCH; c++) begin
            rd(slot_addr(c, 2), v); check("R8 loser counts kept", v, m_cnt[c]);
        end

        // R10: same-cycle register write to the served channel wins its slot
        wr(slot_addr(2, 1), 32'h1);
        wr(slot_addr(2, 2), 32'd10);
        @(negedge clk);
        reg_addr = slot_addr(2, 1); reg_wdata = 32'h401; reg_we = 1'b1;
        req_vld = 8'b0000_0100; req_dwr = '1; req_len[2*DW +: DW] = 32'd4;
        @(negedge clk);
        reg_we = 1'b0; req_vld = '0;
        check("R10 grant uses old values", xfer_len, 32'd4);
        rd(slot_addr(2, 1), v); check("R10 control written wins", v, 32'h401);
        rd(slot_addr(2, 2), v); check("R10 count from request", v, 32'd6);
        @(negedge clk);
        reg_addr = slot_addr(2, 2); reg_wdata = 32'd77; reg_we = 1'b1;
        req_vld = 8'b0000_0100; req_len[2*DW +: DW] = 32'd4;
        @(negedge clk);
        reg_we = 1'b0; req_vld = '0;
        check("R10 grant len", xfer_len, 32'd4);
        rd(slot_addr(2, 2), v); check("R10 count written wins", v, 32'd77);
        rd(slot_addr(2, 1), v); check("R10 control from request", v, 32'h101);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule